// File: doc/BRIEF.md
# Supply-Loss Bus Access Gate

This block sits between the supply-monitoring comparators of a timekeeping core and its host register interface. From three digital status flags it decides two things. The first is whether the host may read or write the core's registers. The second is which supply should feed the core. The three flags are: main rail above the power-fail trip level, main rail above the stronger backup source, and backup A above backup B. The analog comparators, the reference and the power switches live elsewhere. Here they are only input flags.

When the main rail drops below the trip level, host access is cut off at once and a low-power indication is raised. The register contents are not touched. When the rail comes back, access returns only after a programmable recovery interval, counted in clock cycles. The interval is skipped if the oscillator is stopped or its divider chain is held in reset. A stopped oscillator also gets a one-cycle enable-set pulse. If the rail dips again during the interval, the interval starts over from the beginning on the next return.

Top module: `pwr_access_gate`

## Requirements
- R1: While rst_n is low, bus_en is 0, low_power is 1, core_src is 2'b00 and osc_start is 0.
- R2: If main_ok is sampled low at a clock edge, bus_en is 0 after that edge, whatever the backup flags are.
- R3: core_src is registered. After each edge it encodes the flags sampled at that edge: 2'b01 (backup A) when main_ok=0, main_gt_bak=0 and a_gt_b=1; 2'b10 (backup B) when main_ok=0, main_gt_bak=0 and a_gt_b=0; 2'b00 (main rail) in every other combination.
- R4: core_src never takes the value 2'b11.
- R5: Suppose the first edge that samples main_ok high after a low period also samples osc_run=1 and div_hold=0, and main_ok stays high. Then bus_en stays 0 for the next REC_CYCLES-1 edges and becomes 1 after the REC_CYCLES-th edge following that first edge.
- R6: If main_ok is sampled low while the recovery interval is running, the interval is abandoned. The next return of main_ok must wait a fresh full REC_CYCLES interval.
- R7: If osc_run is 0 at the edge that first samples main_ok high, bus_en becomes 1 right after that edge. osc_start is 1 for exactly that one cycle.
- R8: If osc_run is 1 and div_hold is 1 at that edge, bus_en becomes 1 right after that edge and osc_start stays 0.
- R9: low_power is 1 exactly while access is blocked because of a low main rail. It rises after the edge that samples main_ok low and falls after the edge that samples it high, including during the recovery interval.
- R10: While main_ok stays high, a granted bus_en stays 1; the recovery interval is started only by a return of main_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_ok | input | 1 | Main rail above power-fail trip level |
| main_gt_bak | input | 1 | Main rail above the stronger backup source |
| a_gt_b | input | 1 | Backup A above backup B |
| osc_run | input | 1 | Oscillator enable status |
| div_hold | input | 1 | Divider chain held in reset |
| bus_en | output | 1 | Host read/write access granted |
| core_src | output | 2 | Selected core supply code |
| osc_start | output | 1 | One-cycle request to set the oscillator enable |
| low_power | output | 1 | Low-power (access blocked by supply loss) indication |

## Verification
The assertions assume that every input flag is synchronous to clk and stable around the sampling edge. They also assume that osc_run and div_hold are meaningful only at the edge where main_ok first returns high. The bench changes every input one time unit after a rising edge and samples the outputs at that same point. Each flag therefore holds a settled value for a full cycle before any edge uses it. Backup-flag combinations are swept both with the main rail up and with it down, so that the selector is seen apart from the gating state.

// File: rtl/pag_pkg.sv
package pag_pkg;

   typedef enum logic [1:0] {
      SRC_MAIN  = 2'b00,
      SRC_BAK_A = 2'b01,
      SRC_BAK_B = 2'b10
   } src_e;

   typedef enum logic [1:0] {
      GS_BLOCKED = 2'b00,
      GS_RECOVER = 2'b01,
      GS_OPEN    = 2'b10
   } gate_e;

endpackage

// File: rtl/pag_src_sel.sv
module pag_src_sel
   import pag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       main_ok,
   input  logic       main_gt_bak,
   input  logic       a_gt_b,
   output logic [1:0] src
);

   src_e src_d;
   src_e src_q;

   always_comb begin
      src_d = SRC_MAIN;
      if (!main_ok && !main_gt_bak) begin
         src_d = a_gt_b ? SRC_BAK_A : SRC_BAK_B;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= SRC_MAIN;
      else        src_q <= src_d;
   end

   assign src = src_q;

   p_src_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      src != 2'b11);

   p_main_when_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (main_ok || main_gt_bak) |=> src == 2'b00);

   p_bak_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_ok && !main_gt_bak && a_gt_b) |=> src == 2'b01);

   p_bak_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_ok && !main_gt_bak && !a_gt_b) |=> src == 2'b10);

endmodule

// File: rtl/pag_rec_timer.sv
module pag_rec_timer #(
   parameter int unsigned REC_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clr,
   output logic expire
);

   localparam int unsigned CNT_W = $clog2((REC_CYCLES > 1) ? REC_CYCLES : 2);

   generate
      if (REC_CYCLES == 0) begin : g_none
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, load, clr};
         assign expire = 1'b1;
      end else begin : g_cnt
         localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(REC_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;
         logic             run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (clr) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (load) begin
               cnt_q <= LOAD_V;
               run_q <= 1'b1;
            end else if (run_q && cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign expire = run_q && (cnt_q == '0);

         p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> (cnt_q <= LOAD_V));

         p_cnt_moves_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && !clr && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

         p_clr_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !run_q);
      end
   endgenerate

endmodule

// File: rtl/pag_gate_fsm.sv
module pag_gate_fsm
   import pag_pkg::*;
#(
   parameter bit SKIP_WAIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_ok,
   input  logic osc_run,
   input  logic div_hold,
   input  logic expire,
   output logic load,
   output logic clr,
   output logic bus_en,
   output logic osc_start,
   output logic low_power
);

   gate_e st_q, st_d;
   logic  start_d, start_q;
   logic  no_wait;

   assign no_wait = SKIP_WAIT || !osc_run || div_hold;

   always_comb begin
      st_d    = st_q;
      start_d = 1'b0;
      load    = 1'b0;
      clr     = 1'b0;
      unique case (st_q)
         GS_BLOCKED: begin
            if (main_ok) begin
               if (no_wait) begin
                  st_d    = GS_OPEN;
                  start_d = !osc_run;
               end else begin
                  st_d = GS_RECOVER;
                  load = 1'b1;
               end
            end
         end
         GS_RECOVER: begin
            if (!main_ok) begin
               st_d = GS_BLOCKED;
               clr  = 1'b1;
            end else if (expire) begin
               st_d = GS_OPEN;
               clr  = 1'b1;
            end
         end
         GS_OPEN: begin
            if (!main_ok) st_d = GS_BLOCKED;
         end
         default: st_d = GS_BLOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= GS_BLOCKED;
         start_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         start_q <= start_d;
      end
   end

   assign bus_en    = (st_q == GS_OPEN);
   assign low_power = (st_q == GS_BLOCKED);
   assign osc_start = start_q;

   p_block_on_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !main_ok |=> !bus_en);

   p_lowpwr_on_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !main_ok |=> low_power);

   p_lowpwr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |-> !bus_en);

   p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      osc_start |=> !osc_start);

   p_start_grants_r7: assert property (@(posedge clk) disable iff (!rst_n)
      osc_start |-> bus_en);

   p_hold_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && main_ok) |=> bus_en);

endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate #(
   parameter int unsigned REC_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       main_ok,
   input  logic       main_gt_bak,
   input  logic       a_gt_b,
   input  logic       osc_run,
   input  logic       div_hold,
   output logic       bus_en,
   output logic [1:0] core_src,
   output logic       osc_start,
   output logic       low_power
);

   localparam bit SKIP_WAIT = (REC_CYCLES == 0);

   generate
      if (REC_CYCLES > (1 << 24)) begin : g_bad_rec
         $error("REC_CYCLES exceeds the supported counter range");
      end
   endgenerate

   logic tmr_load;
   logic tmr_clr;
   logic tmr_expire;

   pag_src_sel u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .main_ok     (main_ok),
      .main_gt_bak (main_gt_bak),
      .a_gt_b      (a_gt_b),
      .src         (core_src)
   );

   pag_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tmr_load),
      .clr    (tmr_clr),
      .expire (tmr_expire)
   );

   pag_gate_fsm #(.SKIP_WAIT(SKIP_WAIT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_ok   (main_ok),
      .osc_run   (osc_run),
      .div_hold  (div_hold),
      .expire    (tmr_expire),
      .load      (tmr_load),
      .clr       (tmr_clr),
      .bus_en    (bus_en),
      .osc_start (osc_start),
      .low_power (low_power)
   );

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!bus_en && low_power && core_src == 2'b00 && !osc_start));

endmodule

// File: tb/sim_pwr_access_gate.sv
module sim_pwr_access_gate;

   localparam time CLK_PERIOD = 10;
   localparam int  NREC       = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       main_ok, main_gt_bak, a_gt_b, osc_run, div_hold;
   logic       bus_en, osc_start, low_power;
   logic [1:0] core_src;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_access_gate #(.REC_CYCLES(NREC)) u0 (
      .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .main_gt_bak(main_gt_bak),
      .a_gt_b(a_gt_b), .osc_run(osc_run), .div_hold(div_hold),
      .bus_en(bus_en), .core_src(core_src), .osc_start(osc_start),
      .low_power(low_power)
   );

   // rows: {main_ok, main_gt_bak, a_gt_b, expected core_src}
   localparam logic [4:0] SRC_VEC [8] = '{
      {1'b0, 1'b0, 1'b1, 2'b01},
      {1'b0, 1'b0, 1'b0, 2'b10},
      {1'b0, 1'b1, 1'b1, 2'b00},
      {1'b0, 1'b1, 1'b0, 2'b00},
      {1'b1, 1'b0, 1'b1, 2'b00},
      {1'b1, 1'b0, 1'b0, 2'b00},
      {1'b1, 1'b1, 1'b0, 2'b00},
      {1'b0, 1'b0, 1'b1, 2'b01}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic go_low();
      main_ok = 1'b0;
      step();
      step();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; main_ok = 1'b1; main_gt_bak = 1'b1; a_gt_b = 1'b0;
      osc_run = 1'b1; div_hold = 1'b0;
      step(); step();
      chk("R1 bus_en",    {1'b0, bus_en},    2'd0);
      chk("R1 low_power", {1'b0, low_power}, 2'd1);
      chk("R1 core_src",  core_src,          2'd0);
      chk("R1 osc_start", {1'b0, osc_start}, 2'd0);
      main_ok = 1'b0;
      step();
      rst_n = 1'b1;
      step();

      // supply selection table (R3, R4) and gating on loss (R2)
      for (int i = 0; i < 8; i++) begin
         {main_ok, main_gt_bak, a_gt_b} = SRC_VEC[i][4:2];
         step();
         chk("R3 core_src", core_src, SRC_VEC[i][1:0]);
         chk("R4 legal code", {1'b0, core_src == 2'b11}, 2'd0);
         if (!SRC_VEC[i][4]) chk("R2 bus_en blocked", {1'b0, bus_en}, 2'd0);
      end

      // recovery interval (R5, R9)
      go_low();
      main_gt_bak = 1'b1; osc_run = 1'b1; div_hold = 1'b0;
      main_ok = 1'b1;
      step();
      chk("R9 low_power off in recovery", {1'b0, low_power}, 2'd0);
      for (int k = 1; k < NREC; k++) step();
      chk("R5 still blocked at N-1", {1'b0, bus_en}, 2'd0);
      step();
      chk("R5 granted at N", {1'b0, bus_en}, 2'd1);
      chk("R5 no start pulse", {1'b0, osc_start}, 2'd0);

      // no retrigger while up (R10)
      for (int k = 0; k < 3 * NREC; k++) step();
      chk("R10 grant held", {1'b0, bus_en}, 2'd1);

      // loss blocks immediately (R2, R9)
      main_ok = 1'b0; main_gt_bak = 1'b0; a_gt_b = 1'b1;
      step();
      chk("R2 blocked after loss", {1'b0, bus_en}, 2'd0);
      chk("R9 low_power on loss", {1'b0, low_power}, 2'd1);
      chk("R3 backup A while down", core_src, 2'd1);

      // dip during recovery restarts interval (R6)
      main_gt_bak = 1'b1;
      main_ok = 1'b1;
      step(); step(); step();
      main_ok = 1'b0;
      step();
      chk("R6 blocked after dip", {1'b0, bus_en}, 2'd0);
      main_ok = 1'b1;
      step();
      for (int k = 1; k < NREC; k++) step();
      chk("R6 fresh interval not yet done", {1'b0, bus_en}, 2'd0);
      step();
      chk("R6 granted after fresh interval", {1'b0, bus_en}, 2'd1);

      // stopped oscillator: immediate grant and start pulse (R7)
      go_low();
      osc_run = 1'b0;
      main_ok = 1'b1;
      step();
      chk("R7 immediate grant", {1'b0, bus_en}, 2'd1);
      chk("R7 start pulse", {1'b0, osc_start}, 2'd1);
      osc_run = 1'b1;
      step();
      chk("R7 pulse one cycle", {1'b0, osc_start}, 2'd0);
      chk("R7 grant kept", {1'b0, bus_en}, 2'd1);

      // divider held: immediate grant, no pulse (R8)
      go_low();
      div_hold = 1'b1;
      main_ok = 1'b1;
      step();
      chk("R8 immediate grant", {1'b0, bus_en}, 2'd1);
      chk("R8 no start pulse", {1'b0, osc_start}, 2'd0);
      div_hold = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule